// File: doc/BRIEF.md
# DDR2 Bank Timing Guard

This block sits between the command generator of a DDR2 memory controller and the command pins of the device. It follows the state of each bank, open or idle, and keeps a set of down-counters per bank, one for each minimum row timing. Every decoded command is judged in the cycle it arrives. A legal command is forwarded unchanged. An illegal one raises `stall_o` and is replaced on the output by a no-operation, so the generator can hold the command and present it again later.

The minimum timings are given as picosecond parameters together with the clock period. Each is rounded up to whole clock cycles when the design is elaborated. The block also does three more jobs. It computes the read and write data latencies from the CAS and additive latency settings. It closes a bank by itself after a read or write issued with the auto-precharge bit set. It raises a refresh request when the refresh interval expires, and that interval halves while the hot-range flag is set.

Top module: `ddr2_bank_guard`

## Requirements
- R1: After reset every bank is idle, `ref_due_o` is 0, and a no-operation passes with `stall_o` low.
- R2: A read (code 2) or write (code 3) is legal only when its bank is open, at least tRCD cycles (default 5) after that bank's activate, and the bank has no pending auto-precharge. Otherwise `stall_o` is 1 and `cmd_o` is 0.
- R3: A precharge (code 4) to an open bank is legal only at least tRAS cycles (default 15) after its activate, and it closes the bank. A precharge to an idle bank is legal, changes no state and starts no tRP wait.
- R4: An activate (code 1) is legal only when the bank is idle, at least tRC cycles since that bank's previous activate, and at least tRP cycles (default 5) since it closed.
- R5: A precharge-all (code 5) is legal only if no open bank is still inside tRAS and no bank has an auto-precharge pending. It closes all banks, and no activate is then legal for tRPA cycles (default 5).
- R6: `rd_lat_o` equals `al_i + cl_i`, and `wr_lat_o` equals `rd_lat_o - 1`.
- R7: A read or write with `a10_i` = 1 closes its bank without a precharge command. The bank closes `al_i` + BL/2 cycles after a read, or `wr_lat_o` + BL/2 cycles after a write (BL = 8 when `bl8_i` = 1, else 4), but never before tRAS has elapsed. tRP then runs. While the close is pending, every command to that bank stalls and the bank still reads as open.
- R8: An auto-refresh (code 6) is legal only when all banks are idle, none has an auto-precharge pending, and every bank's tRP wait is over.
- R9: `ref_due_o` rises tREFI cycles after the last issued refresh. tREFI is ceil(tREFI_ps/tCK_ps), and the value is halved (rounded up) while `hot_i` = 1. An issued refresh clears the request in the next cycle.
- R10: A no-operation (code 0) is never stalled. The reserved code 7 is always stalled.
- R11: Banks are independent: timing started by a command on one bank does not affect whether commands to another bank are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh, 7 reserved |
| bank_i | input | 2 | Bank address |
| a10_i | input | 1 | Auto-precharge bit for reads and writes |
| hot_i | input | 1 | Case temperature in the upper range; halves the refresh interval |
| cl_i | input | 3 | CAS latency setting (3 to 6) |
| al_i | input | 3 | Additive latency setting |
| bl8_i | input | 1 | Burst length 8 when 1, 4 when 0 |
| cmd_o | output | 3 | Forwarded command, nop when stalled |
| bank_o | output | 2 | Forwarded bank address |
| a10_o | output | 1 | Forwarded auto-precharge bit |
| stall_o | output | 1 | Current command is illegal and was not forwarded |
| open_o | output | 4 | Per-bank open status |
| rd_lat_o | output | 4 | Read latency in cycles |
| wr_lat_o | output | 4 | Write latency in cycles |
| ref_due_o | output | 1 | Refresh interval expired |

## Verification
Two functions can fall in the same cycle. The first case is the internal auto-precharge closing a bank in the cycle a new command for that bank arrives. The bench issues an activate in exactly the cycle where tRAS expires during a pending close. It expects a stall, because the command is judged on the state before the close, and it expects the bank to read as closed on the next cycle. The second case is a refresh issued in a cycle where the refresh request is already high, with the hot flag switched just before. The bench checks that the request drops on the following cycle and then rises again after the halved interval.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_RSV  = 3'd7
  } cmd_e;

  function automatic int ceil_cyc(input int ps, input int tck_ps);
    return (ps + tck_ps - 1) / tck_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track #(
  parameter int CNT_W = 6,
  parameter int RCD_C = 5,
  parameter int RAS_C = 15,
  parameter int RC_C  = 20,
  parameter int RP_C  = 5,
  parameter int RPA_C = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rdwr_i,
  input  logic             ap_i,
  input  logic [CNT_W-1:0] ap_dly_i,
  input  logic             pre_i,
  input  logic             prea_i,
  output logic             open_o,
  output logic             act_ok_o,
  output logic             rdwr_ok_o,
  output logic             pre_ok_o,
  output logic             quiet_o
);

  logic             open_q, pend_q;
  logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q, ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      ap_q   <= '0;
    end else begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (rc_q  != '0) rc_q  <= rc_q  - 1'b1;
      if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
      if (pend_q && ap_q != '0) ap_q <= ap_q - 1'b1;

      if (act_i) begin
        open_q <= 1'b1;
        rcd_q  <= CNT_W'(RCD_C - 1);
        ras_q  <= CNT_W'(RAS_C - 1);
        rc_q   <= CNT_W'(RC_C - 1);
      end
      if (rdwr_i && ap_i) begin
        pend_q <= 1'b1;
        ap_q   <= ap_dly_i - 1'b1;
      end
      // precharge of an idle bank is a no-op
      if (pre_i && open_q) begin
        open_q <= 1'b0;
        rp_q   <= CNT_W'(RP_C - 1);
      end
      if (prea_i) begin
        open_q <= 1'b0;
        rp_q   <= CNT_W'(RPA_C - 1);
      end
      // internal close waits for both burst end and tRAS
      if (pend_q && ap_q == '0 && ras_q == '0) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
        rp_q   <= CNT_W'(RP_C - 1);
      end
    end
  end

  assign open_o    = open_q;
  assign act_ok_o  = !open_q && !pend_q && rc_q == '0 && rp_q == '0;
  assign rdwr_ok_o = open_q && !pend_q && rcd_q == '0;
  assign pre_ok_o  = !pend_q && (!open_q || ras_q == '0);
  assign quiet_o   = !open_q && !pend_q && rp_q == '0;

endmodule

// File: rtl/ddr2_refresh_timer.sv
module ddr2_refresh_timer #(
  parameter int REFI_C     = 2600,
  parameter int REFI_HOT_C = 1300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic ref_i,
  output logic due_o
);

  localparam int W = $clog2(REFI_C + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (ref_i)              cnt_q <= W'(1);
    else if (cnt_q < W'(REFI_C)) cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = cnt_q >= (hot_i ? W'(REFI_HOT_C) : W'(REFI_C));

endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TCK_PS    = 3000,
  parameter int TRCD_PS   = 15000,
  parameter int TRAS_PS   = 45000,
  parameter int TRC_PS    = 60000,
  parameter int TRP_PS    = 15000,
  parameter int TRPA_PS   = 15000,
  parameter int TREFI_PS  = 7800000,
  parameter int LAT_W     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         a10_i,
  input  logic                         hot_i,
  input  logic [2:0]                   cl_i,
  input  logic [2:0]                   al_i,
  input  logic                         bl8_i,
  output logic [2:0]                   cmd_o,
  output logic [$clog2(NUM_BANKS)-1:0] bank_o,
  output logic                         a10_o,
  output logic                         stall_o,
  output logic [NUM_BANKS-1:0]         open_o,
  output logic [LAT_W-1:0]             rd_lat_o,
  output logic [LAT_W-1:0]             wr_lat_o,
  output logic                         ref_due_o
);

  localparam int BA_W       = $clog2(NUM_BANKS);
  localparam int RCD_C      = ceil_cyc(TRCD_PS, TCK_PS);
  localparam int RAS_C      = ceil_cyc(TRAS_PS, TCK_PS);
  localparam int RC_C       = ceil_cyc(TRC_PS, TCK_PS);
  localparam int RP_C       = ceil_cyc(TRP_PS, TCK_PS);
  localparam int RPA_C      = ceil_cyc(TRPA_PS, TCK_PS);
  localparam int REFI_C     = ceil_cyc(TREFI_PS, TCK_PS);
  localparam int REFI_HOT_C = ceil_cyc(TREFI_PS / 2, TCK_PS);
  localparam int CNT_W      = $clog2(max2(max2(RC_C, RAS_C), max2(RPA_C, 1 << LAT_W)) + 1);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [NUM_BANKS-1:0] act_ok, rdwr_ok, pre_ok, quiet;
  logic [NUM_BANKS-1:0] act_go, rdwr_go, pre_go;
  logic                 legal, prea_go, ref_go;
  logic [LAT_W-1:0]     rd_lat, wr_lat;
  logic [CNT_W-1:0]     ap_dly;

  assign rd_lat = LAT_W'(al_i) + LAT_W'(cl_i);
  assign wr_lat = rd_lat - 1'b1;

  always_comb begin
    ap_dly = (cmd == CMD_RD) ? CNT_W'(al_i) : CNT_W'(wr_lat);
    ap_dly = ap_dly + (bl8_i ? CNT_W'(4) : CNT_W'(2));
  end

  always_comb begin
    unique case (cmd)
      CMD_NOP:         legal = 1'b1;
      CMD_ACT:         legal = act_ok[bank_i];
      CMD_RD, CMD_WR:  legal = rdwr_ok[bank_i];
      CMD_PRE:         legal = pre_ok[bank_i];
      CMD_PREA:        legal = &pre_ok;
      CMD_REF:         legal = &quiet;
      default:         legal = 1'b0;
    endcase
  end

  assign prea_go = legal && cmd == CMD_PREA;
  assign ref_go  = legal && cmd == CMD_REF;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit        = legal && bank_i == BA_W'(b);
    assign act_go[b]  = hit && cmd == CMD_ACT;
    assign rdwr_go[b] = hit && (cmd == CMD_RD || cmd == CMD_WR);
    assign pre_go[b]  = hit && cmd == CMD_PRE;

    ddr2_bank_track #(
      .CNT_W (CNT_W),
      .RCD_C (RCD_C),
      .RAS_C (RAS_C),
      .RC_C  (RC_C),
      .RP_C  (RP_C),
      .RPA_C (RPA_C)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act_go[b]),
      .rdwr_i    (rdwr_go[b]),
      .ap_i      (a10_i),
      .ap_dly_i  (ap_dly),
      .pre_i     (pre_go[b]),
      .prea_i    (prea_go),
      .open_o    (open_o[b]),
      .act_ok_o  (act_ok[b]),
      .rdwr_ok_o (rdwr_ok[b]),
      .pre_ok_o  (pre_ok[b]),
      .quiet_o   (quiet[b])
    );
  end

  ddr2_refresh_timer #(
    .REFI_C     (REFI_C),
    .REFI_HOT_C (REFI_HOT_C)
  ) u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hot_i  (hot_i),
    .ref_i  (ref_go),
    .due_o  (ref_due_o)
  );

  assign stall_o  = !legal;
  assign cmd_o    = legal ? cmd_i : 3'(CMD_NOP);
  assign bank_o   = bank_i;
  assign a10_o    = a10_i;
  assign rd_lat_o = rd_lat;
  assign wr_lat_o = wr_lat;

endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      cmd_i,
  input logic [2:0]      cmd_o,
  input logic [BA_W-1:0] bank_o,
  input logic            stall_o,
  input logic [NB-1:0]   open_o,
  input logic            ref_due_o
);

  a_r1_stall_forwards_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> cmd_o == 3'd0);

  a_r2_rdwr_to_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd2 || cmd_o == 3'd3) |-> open_o[bank_o]);

  a_r3_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd4 |=> !open_o[$past(bank_o)]);

  a_r4_act_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd1 |-> !open_o[bank_o]);

  a_r5_prea_closes_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd5 |=> open_o == '0);

  a_r8_ref_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd6 |-> open_o == '0);

  a_r9_ref_clears_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd6 |=> !ref_due_o);

  a_r10_nop_never_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd0 |-> !stall_o);

endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(
  .NB   (NUM_BANKS),
  .BA_W ($clog2(NUM_BANKS))
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     (cmd_i),
  .cmd_o     (cmd_o),
  .bank_o    (bank_o),
  .stall_o   (stall_o),
  .open_o    (open_o),
  .ref_due_o (ref_due_o)
);

// File: tb/ddr2_bank_guard_test.sv
module ddr2_bank_guard_test;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, PREA = 3'd5, REF = 3'd6, RSV = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_i = NOP;
  logic [1:0] bank_i = '0;
  logic       a10_i = 1'b0, hot_i = 1'b0, bl8_i = 1'b0;
  logic [2:0] cl_i = 3'd4, al_i = 3'd1;
  logic [2:0] cmd_o;
  logic [1:0] bank_o;
  logic       a10_o, stall_o, ref_due_o;
  logic [3:0] open_o, rd_lat_o, wr_lat_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ddr2_bank_guard #(.TRC_PS(66000), .TREFI_PS(60000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
    .hot_i(hot_i), .cl_i(cl_i), .al_i(al_i), .bl8_i(bl8_i), .cmd_o(cmd_o),
    .bank_o(bank_o), .a10_o(a10_o), .stall_o(stall_o), .open_o(open_o),
    .rd_lat_o(rd_lat_o), .wr_lat_o(wr_lat_o), .ref_due_o(ref_due_o));

  task automatic chk(input string req, input int act, input int e_val);
    n_chk++;
    if (act != e_val) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, e_val);
    end
  endtask

  // one command per cycle; checks stall and forwarded command before the edge
  task automatic step(input logic [2:0] c, input int b, input logic a10,
                      input bit ok, input string req);
    @(negedge clk);
    cmd_i = c; bank_i = 2'(b); a10_i = a10;
    #1;
    chk({req, " stall"}, int'(stall_o), ok ? 0 : 1);
    chk({req, " cmd_o"}, int'(cmd_o), ok ? int'(c) : 0);
    @(posedge clk);
    #1;
    cmd_i = NOP; a10_i = 1'b0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 1'b0, 1'b1, "R10 nop");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 open", int'(open_o), 0);
    chk("R1 due", int'(ref_due_o), 0);
    chk("R1 stall", int'(stall_o), 0);

    // R6 latency sweep
    for (int c = 3; c <= 6; c++)
      for (int a = 0; a <= 4; a++) begin
        cl_i = 3'(c); al_i = 3'(a); #1;
        chk("R6 rd_lat", int'(rd_lat_o), a + c);
        chk("R6 wr_lat", int'(wr_lat_o), a + c - 1);
      end
    cl_i = 3'd4; al_i = 3'd1;

    // R10 reserved code, R3 precharge to idle bank
    step(RSV, 0, 1'b0, 1'b0, "R10 reserved");
    step(PRE, 3, 1'b0, 1'b1, "R3 pre idle");
    chk("R3 idle pre no open", int'(open_o), 0);
    step(ACT, 3, 1'b0, 1'b1, "R3 act after idle pre");
    chk("R3 b3 open", int'(open_o[3]), 1);
    nops(14);
    step(PRE, 3, 1'b0, 1'b1, "R3 pre b3");
    chk("R3 b3 closed", int'(open_o[3]), 0);
    nops(30);

    // R2 tRCD sweep
    for (int g = 1; g <= 8; g++) begin
      step(ACT, 0, 1'b0, 1'b1, "R4 act");
      nops(g - 1);
      step(RD, 0, 1'b0, g >= 5, "R2 rd after act");
      nops(14 - g);
      step(PRE, 0, 1'b0, 1'b1, "R3 pre");
      nops(30);
    end

    // R3 tRAS sweep
    for (int g = 13; g <= 16; g++) begin
      step(ACT, 0, 1'b0, 1'b1, "R4 act");
      nops(g - 1);
      step(PRE, 0, 1'b0, g >= 15, "R3 pre after act");
      if (g < 15) begin
        nops(15 - g - 1);
        step(PRE, 0, 1'b0, 1'b1, "R3 pre at tRAS");
      end
      chk("R3 closed", int'(open_o[0]), 0);
      nops(30);
    end

    // R4 tRC sweep (tRC = 22)
    for (int g = 18; g <= 23; g++) begin
      step(ACT, 0, 1'b0, 1'b1, "R4 act");
      nops(14);
      step(PRE, 0, 1'b0, 1'b1, "R3 pre");
      nops(g - 16);
      step(ACT, 0, 1'b0, g >= 22, "R4 tRC");
      if (g < 22) begin
        nops(22 - g - 1);
        step(ACT, 0, 1'b0, 1'b1, "R4 tRC end");
      end
      nops(14);
      step(PRE, 0, 1'b0, 1'b1, "R3 pre");
      nops(30);
    end

    // R4 tRP sweep
    for (int g = 3; g <= 6; g++) begin
      step(ACT, 1, 1'b0, 1'b1, "R4 act");
      nops(19);
      step(PRE, 1, 1'b0, 1'b1, "R3 pre");
      nops(g - 1);
      step(ACT, 1, 1'b0, g >= 5, "R4 tRP");
      if (g < 5) begin
        nops(5 - g - 1);
        step(ACT, 1, 1'b0, 1'b1, "R4 tRP end");
      end
      nops(14);
      step(PRE, 1, 1'b0, 1'b1, "R3 pre");
      nops(30);
    end

    // R11 independence, R5 precharge-all
    step(ACT, 0, 1'b0, 1'b1, "R11 act b0");
    nops(1);
    step(ACT, 1, 1'b0, 1'b1, "R11 act b1");
    nops(2);
    step(RD, 0, 1'b0, 1'b1, "R11 rd b0");
    step(RD, 1, 1'b0, 1'b0, "R11 rd b1 early");
    step(RD, 1, 1'b0, 1'b1, "R11 rd b1");
    nops(2);
    step(PREA, 0, 1'b0, 1'b0, "R5 prea in tRAS");
    nops(6);
    step(PREA, 0, 1'b0, 1'b1, "R5 prea");
    chk("R5 all closed", int'(open_o), 0);
    for (int g = 1; g <= 5; g++) step(ACT, 2, 1'b0, g >= 5, "R5 tRPA");
    nops(14);
    step(PRE, 2, 1'b0, 1'b1, "R3 pre");
    nops(30);

    // R8 refresh legality
    step(ACT, 1, 1'b0, 1'b1, "R8 act");
    step(REF, 0, 1'b0, 1'b0, "R8 ref bank open");
    nops(13);
    step(PRE, 1, 1'b0, 1'b1, "R3 pre");
    step(REF, 0, 1'b0, 1'b0, "R8 ref in tRP");
    nops(3);
    step(REF, 0, 1'b0, 1'b1, "R8 ref idle");

    // R9 refresh interval, normal then hot
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk); #1;
      chk("R9 due normal", int'(ref_due_o), (k >= 20) ? 1 : 0);
    end
    hot_i = 1'b1; #1;
    chk("R9 due hot", int'(ref_due_o), 1);
    step(REF, 0, 1'b0, 1'b1, "R9 ref while due");
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk); #1;
      chk("R9 due hot interval", int'(ref_due_o), (k >= 10) ? 1 : 0);
    end
    hot_i = 1'b0; #1;
    chk("R9 due back to normal", int'(ref_due_o), 0);
    nops(2);

    // R7 read with auto-precharge (AL=1, BL4: close at tRAS)
    step(ACT, 0, 1'b0, 1'b1, "R7 act");
    nops(4);
    step(RD, 0, 1'b1, 1'b1, "R7 rd ap");
    step(PRE, 0, 1'b0, 1'b0, "R7 pre while pending");
    nops(8);
    chk("R7 still open", int'(open_o[0]), 1);
    step(ACT, 0, 1'b0, 1'b0, "R7 act at close cycle");
    chk("R7 closed", int'(open_o[0]), 0);
    step(RD, 0, 1'b0, 1'b0, "R7 rd after close");
    nops(4);
    step(ACT, 0, 1'b0, 1'b0, "R7 act before tRC");
    step(ACT, 0, 1'b0, 1'b1, "R7 act");
    nops(14);
    step(PRE, 0, 1'b0, 1'b1, "R3 pre");
    nops(30);

    // R7 write with auto-precharge (WL=4, BL8: close 8 cycles later)
    bl8_i = 1'b1;
    step(ACT, 0, 1'b0, 1'b1, "R7 act");
    nops(13);
    step(WR, 0, 1'b1, 1'b1, "R7 wr ap");
    nops(7);
    chk("R7 wr still open", int'(open_o[0]), 1);
    nops(1);
    chk("R7 wr closed", int'(open_o[0]), 0);
    nops(3);
    step(ACT, 0, 1'b0, 1'b0, "R7 act in tRP");
    step(ACT, 0, 1'b0, 1'b1, "R7 act after tRP");
    nops(14);
    step(PRE, 0, 1'b0, 1'b1, "R3 pre");
    nops(5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule